// File: doc/BRIEF.md
# Load Extend and Store Lane Unit

This block sits between a 64-bit data memory port and the integer register file. It has two independent paths. The load path takes the full memory word that was read, the three lowest address bits and a 3-bit access code. It picks out the addressed byte, halfword, word or doubleword, then sign-extends or zero-extends it to the full register width. The store path takes a register value, the three lowest address bits and an access code. It produces a write-data bus with the low bits of the register moved into the addressed byte lanes, and a byte-enable mask with one bit per lane.

Both paths register their results, so each output holds the answer for the inputs that were present on the previous rising clock edge. Address generation, trapping on misaligned addresses and the memory itself belong to neighbouring blocks. The lane offset is aligned to the access size by dropping the address bits below that size. An access code that the block does not support raises an error flag and writes nothing.

Top module: `ls_lane_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge. Otherwise each output shows, one clock later, the result for the inputs sampled at the edge.
- R2: Load code 011 (doubleword) returns all 64 bits of the memory word unchanged.
- R3: Load code 010 (word) sign-extends bit 31 of the selected word. Load code 110 (unsigned word) zero-extends it.
- R4: Load code 001 (halfword) sign-extends bit 15 of the selected halfword. Load code 101 (unsigned halfword) zero-extends it.
- R5: Load code 000 (byte) sign-extends bit 7 of the selected byte. Load code 100 (unsigned byte) zero-extends it.
- R6: The load lane is little-endian. Byte k of the memory word is bits 8k+7..8k. The access begins at the byte given by the address offset, and address bits below the access size are ignored.
- R7: Store codes 000, 001, 010 and 011 (8, 16, 32 and 64 bits) drive a byte-enable mask of 1, 2, 4 or 8 consecutive ones, shifted left by the aligned address offset.
- R8: Store write data carries the low 8, 16, 32 or 64 bits of the source register in the enabled lanes, least significant byte in the lowest enabled lane. Every lane that is not enabled is zero.
- R9: Load code 111 raises `ld_err` and drives a zero load result. Every other load code keeps `ld_err` low.
- R10: Store codes 100 to 111 raise `st_err` and drive a zero byte-enable mask and zero write data. Store codes 000 to 011 keep `st_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 64 | Word read from the data memory |
| ld_addr_lo | input | 3 | Low address bits of the load |
| ld_code | input | 3 | Load width and signedness code |
| st_src | input | 64 | Register value to store |
| st_addr_lo | input | 3 | Low address bits of the store |
| st_code | input | 3 | Store width code |
| ld_result | output | 64 | Extended load value for the register file |
| ld_err | output | 1 | Load code not supported |
| st_wdata | output | 64 | Lane-placed write data |
| st_be | output | 8 | Byte-enable mask, bit k enables lane k |
| st_err | output | 1 | Store code not supported |

## Verification
The assertions check on every cycle the properties that hold for any data. An enabled mask has a legal count of ones. No write-data bit lies outside the enabled lanes. A store error comes with an empty mask. The doubleword load passes the word through unchanged. The unsigned word load clears the upper half. Both error flags follow their codes. Whether the correct lane was selected for each offset, and whether the sign was extended from the correct bit, can only be shown by the bench. It sweeps every code against every offset, runs directed sign-boundary values, and runs random traffic, all compared with values computed independently.

// File: rtl/lsl_pkg.sv
// Package: shared access-code encodings for the load extend and store lane unit.
// Assumes a 3-bit code whose bits 1:0 give log2 of the access size in bytes
// and whose bit 2 marks an unsigned load (or an unsupported store).
package lsl_pkg;

    typedef enum logic [2:0] {
        ACC_B  = 3'b000,
        ACC_H  = 3'b001,
        ACC_W  = 3'b010,
        ACC_D  = 3'b011,
        ACC_BU = 3'b100,
        ACC_HU = 3'b101,
        ACC_WU = 3'b110,
        ACC_XX = 3'b111
    } acc_code_e;

    localparam int SZ_W = 2;

endpackage

// File: rtl/lsl_load_extend.sv
// Module: load lane extraction and extension.
// Selects the addressed lane of a memory word (little-endian, offset aligned
// down to the access size) and extends it to DATA_W bits. Purely combinational.
// Assumes that the size field of the code never asks for more than DATA_W bits.
module lsl_load_extend #(
    parameter  int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [2:0]        code,
    output logic [DATA_W-1:0] result,
    output logic              err
);
    import lsl_pkg::*;

    localparam int NSZ = OFS_W + 1;

    logic [SZ_W-1:0]   sz;
    logic              sign_en;
    logic [OFS_W-1:0]  lo_mask;
    logic [OFS_W-1:0]  off_al;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] cand [NSZ];

    // Decode the size and signedness, then align the offset to the size.
    always_comb begin
        sz      = code[SZ_W-1:0];
        sign_en = ~code[2];
        lo_mask = ~OFS_W'((1 << sz) - 1);
        off_al  = addr_lo & lo_mask;
        shifted = rdata >> {off_al, 3'b000};
    end

    // One extended candidate per access size.
    for (genvar k = 0; k < NSZ; k++) begin : g_size
        localparam int BW = 8 << k;
        if (BW < DATA_W) begin : g_ext
            logic fill;
            assign fill    = sign_en & shifted[BW-1];
            assign cand[k] = {{(DATA_W-BW){fill}}, shifted[BW-1:0]};
        end else begin : g_full
            assign cand[k] = shifted;
        end
    end

    // Flag the unsupported code and pick the candidate for the size.
    always_comb begin
        err    = (code[2] == 1'b1) && (int'(sz) == NSZ - 1);
        result = err ? '0 : cand[sz];
    end

endmodule

// File: rtl/lsl_store_lanes.sv
// Module: store lane placement and byte-enable generation.
// Places the low bytes of the source into the addressed lanes, zeroes every
// other lane and builds the matching byte-enable mask. Purely combinational.
// Assumes that codes with bit 2 set are not store codes.
module lsl_store_lanes #(
    parameter  int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [2:0]        code,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic              err
);
    import lsl_pkg::*;

    logic [SZ_W-1:0]   sz;
    logic [OFS_W-1:0]  off_al;
    logic [LANES-1:0]  base_be;
    logic [DATA_W-1:0] lane_mask;

    // Build the enable mask for the size and aligned offset.
    always_comb begin
        sz      = code[SZ_W-1:0];
        err     = code[2];
        off_al  = addr_lo & ~OFS_W'((1 << sz) - 1);
        base_be = LANES'((1 << (1 << sz)) - 1);
        be      = err ? '0 : (base_be << off_al);
    end

    // Expand each enable bit into a byte-wide data mask.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{be[i]}};
    end

    // Shift the source into place and clear the lanes that are not enabled.
    always_comb wdata = (src << {off_al, 3'b000}) & lane_mask;

endmodule

// File: rtl/ls_lane_unit.sv
// Module: top of the load extend and store lane unit.
// Runs the load and store paths side by side and registers all their results
// with a synchronous active-low reset. Assumes a single clock domain.
module ls_lane_unit #(
    parameter  int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [OFS_W-1:0]  ld_addr_lo,
    input  logic [2:0]        ld_code,
    input  logic [DATA_W-1:0] st_src,
    input  logic [OFS_W-1:0]  st_addr_lo,
    input  logic [2:0]        st_code,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_err,
    output logic [DATA_W-1:0] st_wdata,
    output logic [LANES-1:0]  st_be,
    output logic              st_err
);
    logic [DATA_W-1:0] ld_val;
    logic              ld_bad;
    logic [DATA_W-1:0] st_val;
    logic [LANES-1:0]  st_en;
    logic              st_bad;

    lsl_load_extend #(.DATA_W(DATA_W)) u_load (
        .rdata   (mem_rdata),
        .addr_lo (ld_addr_lo),
        .code    (ld_code),
        .result  (ld_val),
        .err     (ld_bad)
    );

    lsl_store_lanes #(.DATA_W(DATA_W)) u_store (
        .src     (st_src),
        .addr_lo (st_addr_lo),
        .code    (st_code),
        .wdata   (st_val),
        .be      (st_en),
        .err     (st_bad)
    );

    // Output stage: capture both paths, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_result <= '0;
            ld_err    <= 1'b0;
            st_wdata  <= '0;
            st_be     <= '0;
            st_err    <= 1'b0;
        end else begin
            ld_result <= ld_val;
            ld_err    <= ld_bad;
            st_wdata  <= st_val;
            st_be     <= st_en;
            st_err    <= st_bad;
        end
    end

endmodule

// File: rtl/lsl_checker.sv
// Module: property checker for ls_lane_unit, attached with bind.
// Relates the registered outputs to the codes sampled one edge earlier.
module lsl_checker #(
    parameter  int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [2:0]        ld_code,
    input logic [2:0]        st_code,
    input logic [DATA_W-1:0] ld_result,
    input logic              ld_err,
    input logic [DATA_W-1:0] st_wdata,
    input logic [LANES-1:0]  st_be,
    input logic              st_err
);
    logic [DATA_W-1:0] be_bits;

    // Byte-wide expansion of the registered mask.
    for (genvar i = 0; i < LANES; i++) begin : g_exp
        assign be_bits[8*i +: 8] = {8{st_be[i]}};
    end

    AST_LDD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_code == 3'b011) |=> (ld_result == $past(mem_rdata))); // R2
    AST_LWU_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_code == 3'b110) |=> (ld_result[DATA_W-1:32] == '0)); // R3
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code[2] == 1'b0) |=> ($countones(st_be) == (1 << $past(st_code[1:0])))); // R7
    AST_WDATA_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_wdata & ~be_bits) == '0)); // R8
    AST_LD_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ld_err == ($past(ld_code) == 3'b111))); // R9
    AST_LD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> (ld_result == '0)); // R9
    AST_ST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_err == $past(st_code[2]))); // R10
    AST_ST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (st_be == '0)); // R10

endmodule

bind ls_lane_unit lsl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .ld_code   (ld_code),
    .st_code   (st_code),
    .ld_result (ld_result),
    .ld_err    (ld_err),
    .st_wdata  (st_wdata),
    .st_be     (st_be),
    .st_err    (st_err)
);

// File: tb/tb_ls_lane_unit.sv
`timescale 1ns/1ps
module tb_ls_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [2:0]  ld_addr_lo = '0;
    logic [2:0]  ld_code = '0;
    logic [63:0] st_src = '0;
    logic [2:0]  st_addr_lo = '0;
    logic [2:0]  st_code = '0;
    logic [63:0] ld_result;
    logic        ld_err;
    logic [63:0] st_wdata;
    logic [7:0]  st_be;
    logic        st_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ls_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .ld_addr_lo(ld_addr_lo),
        .ld_code(ld_code), .st_src(st_src), .st_addr_lo(st_addr_lo), .st_code(st_code),
        .ld_result(ld_result), .ld_err(ld_err), .st_wdata(st_wdata), .st_be(st_be),
        .st_err(st_err)
    );

    function automatic string ld_tag(input logic [2:0] c);
        case (c)
            3'b011:          return "R2";
            3'b010, 3'b110:  return "R3";
            3'b001, 3'b101:  return "R4";
            3'b000, 3'b100:  return "R5";
            default:         return "R9";
        endcase
    endfunction

    // Expected load result, built byte by byte.
    function automatic logic [63:0] exp_ld(input logic [63:0] w, input logic [2:0] a,
                                           input logic [2:0] c);
        int nb = 1 << c[1:0];
        int base = int'(a) - (int'(a) % nb);
        logic [63:0] v = '0;
        if (c == 3'b111) return '0;
        for (int i = 0; i < nb; i++) v[8*i +: 8] = w[8*(base+i) +: 8];
        if (!c[2] && nb < 8 && v[8*nb-1])
            for (int j = 8*nb; j < 64; j++) v[j] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_be(input logic [2:0] a, input logic [2:0] c);
        int nb = 1 << c[1:0];
        int base = int'(a) - (int'(a) % nb);
        logic [7:0] m = '0;
        if (c[2]) return '0;
        for (int i = 0; i < nb; i++) m[base+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] exp_wd(input logic [63:0] s, input logic [2:0] a,
                                           input logic [2:0] c);
        int nb = 1 << c[1:0];
        int base = int'(a) - (int'(a) % nb);
        logic [63:0] v = '0;
        if (c[2]) return '0;
        for (int i = 0; i < nb; i++) v[8*(base+i) +: 8] = s[8*i +: 8];
        return v;
    endfunction

    task automatic check64(input string tag, input string what, input logic [63:0] act,
                           input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one load and one store, wait a cycle, compare all outputs.
    task automatic run_op(input logic [63:0] w, input logic [2:0] la, input logic [2:0] lc,
                          input logic [63:0] s, input logic [2:0] sa, input logic [2:0] sc);
        string stag;
        mem_rdata = w; ld_addr_lo = la; ld_code = lc;
        st_src = s; st_addr_lo = sa; st_code = sc;
        @(negedge clk);
        stag = sc[2] ? "R10" : "R7";
        check64(ld_tag(lc), "ld_result", ld_result, exp_ld(w, la, lc));
        check64("R9", "ld_err", {63'b0, ld_err}, {63'b0, lc == 3'b111});
        check64(stag, "st_be", {56'b0, st_be}, {56'b0, exp_be(sa, sc)});
        check64(sc[2] ? "R10" : "R8", "st_wdata", st_wdata, exp_wd(s, sa, sc));
        check64("R10", "st_err", {63'b0, st_err}, {63'b0, sc[2]});
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: outputs stay zero under reset despite active inputs.
        mem_rdata = 64'hFFFF_FFFF_FFFF_FFFF; ld_code = 3'b011;
        st_src = 64'hFFFF_FFFF_FFFF_FFFF; st_code = 3'b011;
        repeat (3) @(negedge clk);
        check64("R1", "ld_result", ld_result, '0);
        check64("R1", "st_be", {56'b0, st_be}, '0);
        check64("R1", "st_wdata", st_wdata, '0);
        rst_n = 1'b1;
        // R6: sweep every code against every offset.
        for (int c = 0; c < 8; c++)
            for (int a = 0; a < 8; a++)
                run_op(64'h8877_6655_F433_A211, 3'(a), 3'(c),
                       64'h0123_4567_89AB_CDEF, 3'(a), 3'(c));
        // Directed sign boundaries for R3, R4, R5.
        run_op(64'h0000_0080_0000_007F, 3'd0, 3'b000, 64'h80, 3'd7, 3'b000);
        run_op(64'h0000_0080_0000_007F, 3'd4, 3'b000, 64'h80, 3'd6, 3'b001);
        run_op(64'h8000_7FFF_0000_0000, 3'd6, 3'b001, 64'hFFFF, 3'd4, 3'b010);
        run_op(64'h8000_7FFF_0000_0000, 3'd6, 3'b101, 64'h7FFF_FFFF, 3'd0, 3'b011);
        run_op(64'h8000_0000_7FFF_FFFF, 3'd4, 3'b010, 64'h0, 3'd5, 3'b110);
        run_op(64'h8000_0000_7FFF_FFFF, 3'd4, 3'b110, 64'h0, 3'd3, 3'b111);
        run_op(64'h8000_0000_7FFF_FFFF, 3'd0, 3'b010, 64'hDEAD, 3'd1, 3'b001);
        // Random traffic.
        for (int n = 0; n < 400; n++)
            run_op({$urandom, $urandom}, 3'($urandom), 3'($urandom),
                   {$urandom, $urandom}, 3'($urandom), 3'($urandom));
        // R1: re-entering reset clears outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check64("R1", "ld_err", {63'b0, ld_err}, '0);
        check64("R1", "st_err", {63'b0, st_err}, '0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule